// File: doc/BRIEF.md
# Primary-Side Data Parity Error Reporter

This block sits on the primary interface of a two-interface PCI-to-PCI bridge. It keeps the parity status flags for that side. Each cycle it may receive one data-phase parity event. The event carries the transaction kind, the direction of travel, the bus on which the parity was checked, and whether a remote target flagged it rather than the bridge's own checker. The block decides which sticky status flags the event sets. It also decides whether the event must be signalled as a system error on the active-low `serr_n` output.

The bridge sets its own detected flag only when it is the receiver of the data on the primary bus. A remote target can report a parity error on an upstream write that the bridge issued on the primary bus. That report is turned into a system error only when the initiator has no other way of learning about it. This holds when every reporting enable is on and the error was not already carried over from the secondary bus. Software reads the 16-bit status word and clears flags by writing ones under byte selects.

Top module: `ppr_parity_reporter`

## Requirements
- R1: Status bit 15 (detected parity error) is set, whatever the enable inputs are, by an own-checker event (`evt_remote`=0) on the primary bus (`evt_bus`=0) in exactly three cases: an upstream read (`evt_type`=00, `evt_dir`=1), a downstream posted write (`evt_type`=01, `evt_dir`=0), and a downstream delayed write (`evt_type`=10, `evt_dir`=0).
- R2: No event with `evt_bus`=1 (secondary) sets bit 15.
- R3: Bit 15 is not set by any of these primary-bus events: a downstream read, an upstream posted write, an upstream delayed write, or any event with `evt_type`=11.
- R4: Bit 8 (data parity detected) is set by a remote-flagged event (`evt_remote`=1) that is an upstream posted or delayed write on the primary bus, and only when `cfg_perr_resp_pri`=1.
- R5: For the same remote-flagged upstream write, bit 14 (signaled system error) is set only when `cfg_serr_en`, `cfg_perr_resp_sec` and `cfg_perr_resp_pri` are all 1 and `evt_fwd`=0.
- R6: Each event that sets bit 14 under R5 drives `serr_n` low for exactly the one clock cycle after the event's clock edge. `serr_n` is high in every other cycle.
- R7: Status flags are sticky. A flag clears only when `wr_en`=1, the byte select covering it is 1 (`wr_be[1]` for bits 15:8, `wr_be[0]` for bits 7:0), and the matching `wr_data` bit is 1. Bits other than 15, 14 and 8 always read 0.
- R8: When a clear and a set reach the same flag in the same cycle, the flag ends up set.
- R9: Synchronous reset clears all status flags and holds `serr_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | A parity event is present this cycle |
| evt_type | input | 2 | 00 read, 01 posted write, 10 delayed write, 11 reserved |
| evt_dir | input | 1 | 0 downstream, 1 upstream |
| evt_bus | input | 1 | Bus where parity was checked: 0 primary, 1 secondary |
| evt_remote | input | 1 | 1 when a remote target flagged the error |
| evt_fwd | input | 1 | 1 when the error was already detected on the secondary bus and forwarded |
| cfg_perr_resp_pri | input | 1 | Primary parity-error response enable |
| cfg_perr_resp_sec | input | 1 | Secondary parity-error response enable |
| cfg_serr_en | input | 1 | System-error signalling enable |
| wr_en | input | 1 | Status write strobe |
| wr_be | input | 2 | Byte selects for the status write |
| wr_data | input | 16 | Write-one-to-clear data |
| sts_o | output | 16 | Status word |
| serr_n | output | 1 | Active-low system-error pulse |

## Verification
The hardest case to reach from the ports is a clear that lands on the same edge as a new set of the same flag. At the same time, back-to-back qualifying events must stretch `serr_n` over adjacent cycles without merging two pulses into a wrong count. The stimulus first takes directed passes through every type, direction and bus combination. It then runs a long random phase with weighted enables, in which status writes with random byte selects and all-ones data often coincide with events. Both outputs are compared with a behavioural model on every clock.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  typedef enum logic [1:0] {
    XF_READ    = 2'b00,
    XF_POSTED  = 2'b01,
    XF_DELAYED = 2'b10,
    XF_RSVD    = 2'b11
  } xfer_e;

  typedef struct packed {
    logic det;  // bridge detected error as data receiver
    logic dpd;  // remote target reported error on our write
    logic sse;  // system error to be signalled
  } set_req_t;
endpackage

// File: rtl/ppr_classify.sv
module ppr_classify
  import ppr_pkg::*;
(
  input  logic       evt_valid,
  input  logic [1:0] evt_type,
  input  logic       evt_dir,
  input  logic       evt_bus,
  input  logic       evt_remote,
  input  logic       evt_fwd,
  input  logic       cfg_perr_resp_pri,
  input  logic       cfg_perr_resp_sec,
  input  logic       cfg_serr_en,
  output set_req_t   req
);
  xfer_e xf;
  logic  on_pri, is_write, recv_pri, remote_upw;

  always_comb begin
    xf       = xfer_e'(evt_type);
    on_pri   = evt_valid && !evt_bus;
    is_write = (xf == XF_POSTED) || (xf == XF_DELAYED);
    // Bridge is the data receiver on the primary bus
    recv_pri = ((xf == XF_READ) && evt_dir) || (is_write && !evt_dir);
    remote_upw = on_pri && evt_remote && is_write && evt_dir;

    req.det = on_pri && !evt_remote && recv_pri;
    req.dpd = remote_upw && cfg_perr_resp_pri;
    req.sse = remote_upw && cfg_perr_resp_pri && cfg_perr_resp_sec
              && cfg_serr_en && !evt_fwd;
  end
endmodule

// File: rtl/ppr_status.sv
module ppr_status #(
  parameter int STS_W = 16,
  localparam int BE_W = STS_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STS_W-1:0] set_vec,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [STS_W-1:0] wr_data,
  output logic [STS_W-1:0] q
);
  logic [STS_W-1:0] clr_vec;

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign clr_vec[b*8 +: 8] = wr_data[b*8 +: 8] & {8{wr_en & wr_be[b]}};
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_vec) | set_vec;   // set wins
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((q & ~clr_vec) & ~set_vec) != '0 |=> (q & $past(q & ~clr_vec)) == $past(q & ~clr_vec)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_vec & clr_vec) != '0 |=> (q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)); // R8
endmodule

// File: rtl/ppr_serr_gen.sv
module ppr_serr_gen (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic serr_n
);
  always_ff @(posedge clk) begin
    if (rst) serr_n <= 1'b1;
    else     serr_n <= ~fire;
  end

  AST_SERR_HIGH_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fire |=> serr_n); // R6
endmodule

// File: rtl/ppr_parity_reporter.sv
module ppr_parity_reporter
  import ppr_pkg::*;
#(
  parameter int STS_W   = 16,
  parameter int DET_BIT = 15,
  parameter int SSE_BIT = 14,
  parameter int DPD_BIT = 8,
  localparam int BE_W   = STS_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic [1:0]       evt_type,
  input  logic             evt_dir,
  input  logic             evt_bus,
  input  logic             evt_remote,
  input  logic             evt_fwd,
  input  logic             cfg_perr_resp_pri,
  input  logic             cfg_perr_resp_sec,
  input  logic             cfg_serr_en,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [STS_W-1:0] wr_data,
  output logic [STS_W-1:0] sts_o,
  output logic             serr_n
);
  set_req_t         req;
  logic [STS_W-1:0] set_vec;

  ppr_classify u_cls (
    .evt_valid, .evt_type, .evt_dir, .evt_bus, .evt_remote, .evt_fwd,
    .cfg_perr_resp_pri, .cfg_perr_resp_sec, .cfg_serr_en, .req
  );

  always_comb begin
    set_vec          = '0;
    set_vec[DET_BIT] = req.det;
    set_vec[SSE_BIT] = req.sse;
    set_vec[DPD_BIT] = req.dpd;
  end

  ppr_status #(.STS_W(STS_W)) u_sts (
    .clk, .rst, .set_vec, .wr_en, .wr_be, .wr_data, .q(sts_o)
  );

  ppr_serr_gen u_serr (.clk, .rst, .fire(req.sse), .serr_n);

  AST_SERR_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> sts_o[SSE_BIT] || $past(wr_en)); // R5
  AST_SEC_NO_DET: assert property (@(posedge clk) disable iff (rst)
    evt_valid && evt_bus && !sts_o[DET_BIT] |=> !sts_o[DET_BIT]); // R2
  AST_FWD_NO_SERR: assert property (@(posedge clk) disable iff (rst)
    evt_valid && evt_fwd |=> serr_n); // R5
  AST_DPD_NEEDS_RESP: assert property (@(posedge clk) disable iff (rst)
    !cfg_perr_resp_pri && !sts_o[DPD_BIT] |=> !sts_o[DPD_BIT]); // R4
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> sts_o == '0 && serr_n); // R9
endmodule

// File: tb/ppr_parity_reporter_bench.sv
module ppr_parity_reporter_bench;
  logic clk = 0, rst = 1;
  logic evt_valid = 0, evt_dir = 0, evt_bus = 0, evt_remote = 0, evt_fwd = 0;
  logic [1:0] evt_type = 0;
  logic pri = 0, sec = 0, sen = 0;
  logic wr_en = 0;
  logic [1:0] wr_be = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] sts_o;
  logic serr_n;

  int checks = 0, errors = 0;
  string tag = "R9";
  logic [15:0] exp_sts = 0;
  logic exp_serr_n = 1;

  always #2.5 clk = ~clk;

  ppr_parity_reporter u_ppr_parity_reporter (
    .clk, .rst, .evt_valid, .evt_type, .evt_dir, .evt_bus, .evt_remote,
    .evt_fwd, .cfg_perr_resp_pri(pri), .cfg_perr_resp_sec(sec),
    .cfg_serr_en(sen), .wr_en, .wr_be, .wr_data, .sts_o, .serr_n
  );

  // Behavioural reference model, updated on each rising edge
  always @(posedge clk) begin
    bit det, dpd, sse, wr_kind;
    logic [15:0] clr;
    if (rst) begin
      exp_sts = 0; exp_serr_n = 1;
    end else begin
      wr_kind = (evt_type == 2'd1 || evt_type == 2'd2);
      det = evt_valid && !evt_bus && !evt_remote &&
            ((evt_type == 2'd0 && evt_dir) || (wr_kind && !evt_dir));
      dpd = evt_valid && !evt_bus && evt_remote && wr_kind && evt_dir && pri;
      sse = dpd && sec && sen && !evt_fwd;
      clr = 0;
      if (wr_en && wr_be[1]) clr[15:8] = wr_data[15:8];
      if (wr_en && wr_be[0]) clr[7:0]  = wr_data[7:0];
      exp_sts = exp_sts & ~clr;
      if (det) exp_sts[15] = 1;
      if (dpd) exp_sts[8]  = 1;
      if (sse) exp_sts[14] = 1;
      exp_serr_n = !sse;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (sts_o !== exp_sts) begin
      errors++;
      $display("FAIL %s status: actual=%h expected=%h", tag, sts_o, exp_sts);
    end
    checks++;
    if (serr_n !== exp_serr_n) begin
      errors++;
      $display("FAIL %s serr_n: actual=%b expected=%b", tag, serr_n, exp_serr_n);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ev(input logic [1:0] t, input logic d, b, r, f);
    evt_valid = 1; evt_type = t; evt_dir = d; evt_bus = b; evt_remote = r; evt_fwd = f;
    step();
    evt_valid = 0;
  endtask

  task automatic clear_all();
    wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
    step();
    wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tag = "R9"; step(); step(); rst = 0; step();
    // R1 / R3: every primary own-checker combination, enables off
    tag = "R1";
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++) begin
        tag = ((t == 0 && d == 1) || ((t == 1 || t == 2) && d == 0)) ? "R1" : "R3";
        ev(t[1:0], d[0], 0, 0, 0); step(); clear_all();
      end
    // R2: secondary bus, all enables on
    tag = "R2"; pri = 1; sec = 1; sen = 1;
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++) begin ev(t[1:0], d[0], 1, 0, 0); ev(t[1:0], d[0], 1, 1, 0); end
    step();
    // R4: remote upstream write, primary enable on/off
    tag = "R4"; pri = 0; ev(2'd1, 1, 0, 1, 0); step();
    pri = 1; sec = 0; ev(2'd2, 1, 0, 1, 0); step(); clear_all();
    // R5 / R6: system error qualifications, back-to-back pulses
    tag = "R5"; sec = 1; sen = 1; ev(2'd1, 1, 0, 1, 1); step();
    sen = 0; ev(2'd1, 1, 0, 1, 0); step(); sen = 1;
    tag = "R6"; ev(2'd1, 1, 0, 1, 0); ev(2'd2, 1, 0, 1, 0); step(); step();
    // R7: byte-select clears, zero data no effect
    tag = "R7";
    wr_en = 1; wr_be = 2'b01; wr_data = 16'hFFFF; step();
    wr_be = 2'b10; wr_data = 16'h0000; step();
    wr_data = 16'h4000; step();
    wr_data = 16'h8100; step(); wr_en = 0;
    // R8: clear and set on the same edge
    tag = "R8"; wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
    ev(2'd1, 1, 0, 1, 0); wr_en = 0; step();
    // Random phase
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      evt_valid = $urandom_range(0, 3) != 0;
      evt_type = 2'($urandom); evt_dir = 1'($urandom); evt_bus = 1'($urandom);
      evt_remote = 1'($urandom); evt_fwd = ($urandom_range(0, 3) == 0);
      pri = ($urandom_range(0, 3) != 0); sec = ($urandom_range(0, 3) != 0);
      sen = ($urandom_range(0, 3) != 0);
      wr_en = ($urandom_range(0, 4) == 0); wr_be = 2'($urandom);
      wr_data = ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'($urandom);
      step();
    end
    evt_valid = 0; wr_en = 0;
    tag = "R9"; rst = 1; step(); rst = 0; step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule